// File: doc/BRIEF.md
# Register-File Byte Burst Mover

This block copies a run of bytes between a 32-entry, 32-bit register file and a byte-wide data memory, in either direction. A command gives the direction, the starting memory byte address, a byte count, the first register and the first byte lane inside that register. The block moves one byte per cycle. The memory address and the register/lane cursor both advance upward, and the cursor rolls from lane 3 into lane 0 of the next register. A transfer may therefore begin on any lane and spill across as many registers as it needs.

Three fault checks are applied when a command is captured, before any byte moves:

- **Null trap:** an optional trap on the null page.
- **Instruction-space crossing:** an optional guard, enabled for standalone operation, that stops accesses reaching or crossing the instruction-space boundary.
- **Register-file overrun:** a check that the transfer does not run past the end of the register file.

A rejected command raises a one-cycle fault pulse carrying a code, and nothing moves.

An accepted command first spends a fixed access-latency interval of two cycles, and then moves its bytes. The register file and the memory sit outside the block. Both are reached through combinational read paths. The memory is written through a byte write strobe, and the register file through a single-lane byte write.

Top module: `rf_burst_mover`

## Requirements
- R1: `busy` is high from the cycle after the command is captured until the cycle in which the last byte moves. A `cmd_valid` that arrives while `busy` is high is ignored and causes no access.
- R2: Cycle 0 is the first cycle after the capturing edge. Cycles 0 and 1 are latency cycles with no access. Byte i moves in cycle 2+i. `done` pulses for exactly one cycle, in cycle 2+n.
- R3: Memory byte addresses are visited in strictly ascending order: start, start+1, and so on.
- R4: The first byte uses the starting register and lane, and the lane rises by one per byte. After lane 3, the lane returns to 0 and the register index rises by one.
- R5: On a store (`cmd_store`=1), each cycle presents the current register on `rf_ridx`. That cycle raises `mem_we` and drives `mem_wdata` with bits [8*lane+7:8*lane] of `rf_rdata`.
- R6: On a load (`cmd_store`=0), each cycle raises `mem_re` and a single-lane register write. The write carries `rf_widx`=current register, `rf_wlane`=current lane and `rf_wdata`=`mem_rdata`. No other lane of that register is written.
- R7: If start_reg*4 + start_lane + count is greater than 128, the command faults with code 3. A sum of exactly 128 is accepted.
- R8: When `cfg_null_trap`=1, a command whose start address is below 4 faults with code 1. When `cfg_null_trap`=0, the same command is carried out.
- R9: When `cfg_standalone`=1, a command faults with code 2 if its start address is at or above `cfg_imem_base`, or if address+count exceeds `cfg_imem_base`. An end exactly at the base is accepted. When `cfg_standalone`=0, this check is off.
- R10: When several faults apply, the code follows this priority: null trap (1), then instruction-space crossing (2), then overrun (3).
- R11: A fault-free command with a count of zero pulses `done` in cycle 0, performs no memory access, and leaves `busy` low.
- R12: A faulting command pulses `fault` for one cycle, in cycle 0, with its code on `fault_code`. `busy` never rises and no memory or register access occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, captured when idle |
| cmd_store | input | 1 | 1 = register file to memory, 0 = memory to register file |
| cmd_addr | input | ADDR_W | Starting memory byte address |
| cmd_count | input | CNT_W | Number of bytes |
| cmd_reg | input | 5 | Starting register index |
| cmd_lane | input | 2 | Starting byte lane |
| cfg_null_trap | input | 1 | Enables the null-page trap |
| cfg_standalone | input | 1 | Enables the instruction-space guard |
| cfg_imem_base | input | ADDR_W | First address of instruction space |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle rejection pulse |
| fault_code | output | 2 | 1 null trap, 2 instruction space, 3 overrun |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | Memory byte write strobe |
| mem_re | output | 1 | Memory byte read strobe |
| mem_wdata | output | 8 | Byte to memory |
| mem_rdata | input | 8 | Byte from memory, combinational |
| rf_ridx | output | 5 | Register read index |
| rf_rdata | input | 32 | Register read word, combinational |
| rf_we | output | 1 | Register single-lane write strobe |
| rf_widx | output | 5 | Register write index |
| rf_wlane | output | 2 | Lane being written |
| rf_wdata | output | 8 | Byte being written |

## Verification
Every result is due at a fixed offset from the edge that captures a command:

- A fault or a zero-count completion appears in cycle 0.
- Byte i appears in cycle 2+i.
- The closing `done` appears in cycle 2+n.
- `busy` is high over cycles 0 through n+1.

For each command, the driver computes these cycle numbers from a free-running edge counter and stores them with every expected access in the scoreboard queue. The monitor samples on the falling edge. Whenever an access or pulse appears, it compares the current edge count against the stored cycle, so a result that is early, late or missing is reported, as well as one with wrong contents. The monitor also compares `busy` against the predicted window on every cycle, and the queue must be empty once each command has settled.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_NULL    = 2'd1,
        FLT_IMEM    = 2'd2,
        FLT_OVERRUN = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_MOVE = 2'd2
    } state_e;

    // Byte-lane selection from a register word
    function automatic logic [BYTE_W-1:0] pick_lane(input logic [WORD_W-1:0] w,
                                                    input logic [LANE_W-1:0] l);
        return w[l*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/rfb_cmd_check.sv
module rfb_cmd_check
    import rfb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int NREGS  = 32
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [CNT_W-1:0]           count,
    input  logic [$clog2(NREGS)-1:0]   rsel,
    input  logic [LANE_W-1:0]          lane,
    input  logic                       null_en,
    input  logic                       standalone,
    input  logic [ADDR_W-1:0]          imem_base,
    output fault_e                     code
);
    localparam int REG_W      = $clog2(NREGS);
    localparam int POS_W      = REG_W + LANE_W;
    localparam int SUM_W      = ((CNT_W > POS_W) ? CNT_W : POS_W) + 1;
    localparam int FILE_BYTES = NREGS * LANES;
    localparam int END_W      = ADDR_W + 1;

    logic [SUM_W-1:0] span_end;
    logic [END_W-1:0] addr_end;
    logic             hit_null, hit_imem, hit_over;

    always_comb begin
        span_end = SUM_W'({rsel, lane}) + SUM_W'(count);
        addr_end = END_W'(addr) + END_W'(count);
        hit_null = null_en && (addr < ADDR_W'(4));
        hit_imem = standalone && ((addr >= imem_base) || (addr_end > END_W'(imem_base)));
        hit_over = span_end > SUM_W'(FILE_BYTES);
        if (hit_null)      code = FLT_NULL;
        else if (hit_imem) code = FLT_IMEM;
        else if (hit_over) code = FLT_OVERRUN;
        else               code = FLT_NONE;
    end

endmodule

// File: rtl/rfb_cursor.sv
module rfb_cursor
    import rfb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [CNT_W-1:0]  init_count,
    input  logic [REG_W-1:0]  init_reg,
    input  logic [LANE_W-1:0] init_lane,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [REG_W-1:0]  cur_reg,
    output logic [LANE_W-1:0] cur_lane,
    output logic              last
);
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_reg  <= '0;
            cur_lane <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= init_addr;
            cur_reg  <= init_reg;
            cur_lane <= init_lane;
            remain   <= init_count;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(1);
            remain   <= remain - CNT_W'(1);
            if (cur_lane == TOP_LANE) begin
                cur_lane <= '0;
                cur_reg  <= cur_reg + REG_W'(1);
            end else begin
                cur_lane <= cur_lane + LANE_W'(1);
            end
        end
    end

    assign last = (remain == CNT_W'(1));

    // R3: consecutive byte steps visit consecutive addresses
    p_addr_ascend_r3: assert property (@(posedge clk) disable iff (rst)
        (step && $past(step) && !$past(load)) |-> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

    // R4: lane rolls from the top lane to 0 and the register advances
    p_lane_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (step && $past(step) && $past(cur_lane) == TOP_LANE)
            |-> (cur_lane == '0 && cur_reg == $past(cur_reg) + REG_W'(1)));

    // R4: below the top lane the register holds and the lane advances
    p_lane_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (step && $past(step) && $past(cur_lane) != TOP_LANE)
            |-> (cur_lane == $past(cur_lane) + LANE_W'(1) && $stable(cur_reg)));

endmodule

// File: rtl/rfb_lane_pick.sv
module rfb_lane_pick
    import rfb_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] sel,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign byte_out = lane_bytes[sel];

endmodule

// File: rtl/rf_burst_mover.sv
module rf_burst_mover
    import rfb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 8,
    parameter int NREGS      = 32,
    parameter int LAT_CYCLES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic                     cmd_store,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [CNT_W-1:0]         cmd_count,
    input  logic [$clog2(NREGS)-1:0] cmd_reg,
    input  logic [1:0]               cmd_lane,
    input  logic                     cfg_null_trap,
    input  logic                     cfg_standalone,
    input  logic [ADDR_W-1:0]        cfg_imem_base,
    output logic                     busy,
    output logic                     done,
    output logic                     fault,
    output logic [1:0]               fault_code,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_we,
    output logic                     mem_re,
    output logic [7:0]               mem_wdata,
    input  logic [7:0]               mem_rdata,
    output logic [$clog2(NREGS)-1:0] rf_ridx,
    input  logic [31:0]              rf_rdata,
    output logic                     rf_we,
    output logic [$clog2(NREGS)-1:0] rf_widx,
    output logic [1:0]               rf_wlane,
    output logic [7:0]               rf_wdata
);
    localparam int REG_W  = $clog2(NREGS);
    localparam int LAT_W  = (LAT_CYCLES > 1) ? $clog2(LAT_CYCLES) : 1;
    localparam int LAT_M1 = (LAT_CYCLES > 0) ? LAT_CYCLES - 1 : 0;

    state_e            st;
    logic [LAT_W-1:0]  lat_cnt;
    logic              dir_store;
    logic              done_q, fault_q;
    fault_e            code_q;
    fault_e            chk_code;
    logic              accept, start_move, moving;
    logic [ADDR_W-1:0] cur_addr;
    logic [REG_W-1:0]  cur_reg;
    logic [LANE_W-1:0] cur_lane;
    logic              last;
    logic [BYTE_W-1:0] store_byte;

    rfb_cmd_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NREGS(NREGS)) i_check (
        .addr       (cmd_addr),
        .count      (cmd_count),
        .rsel       (cmd_reg),
        .lane       (cmd_lane),
        .null_en    (cfg_null_trap),
        .standalone (cfg_standalone),
        .imem_base  (cfg_imem_base),
        .code       (chk_code)
    );

    assign accept     = cmd_valid && (st == ST_IDLE);
    assign start_move = accept && (chk_code == FLT_NONE) && (cmd_count != '0);
    assign moving     = (st == ST_MOVE);

    rfb_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) i_cursor (
        .clk        (clk),
        .rst        (rst),
        .load       (start_move),
        .step       (moving),
        .init_addr  (cmd_addr),
        .init_count (cmd_count),
        .init_reg   (cmd_reg),
        .init_lane  (cmd_lane),
        .cur_addr   (cur_addr),
        .cur_reg    (cur_reg),
        .cur_lane   (cur_lane),
        .last       (last)
    );

    rfb_lane_pick i_pick (
        .word     (rf_rdata),
        .sel      (cur_lane),
        .byte_out (store_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            lat_cnt   <= '0;
            dir_store <= 1'b0;
            done_q    <= 1'b0;
            fault_q   <= 1'b0;
            code_q    <= FLT_NONE;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        dir_store <= cmd_store;
                        if (chk_code != FLT_NONE) begin
                            fault_q <= 1'b1;
                            code_q  <= chk_code;
                        end else if (cmd_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            lat_cnt <= '0;
                            st      <= (LAT_CYCLES > 0) ? ST_LAT : ST_MOVE;
                        end
                    end
                end
                ST_LAT: begin
                    if (lat_cnt == LAT_W'(LAT_M1)) st <= ST_MOVE;
                    else                           lat_cnt <= lat_cnt + LAT_W'(1);
                end
                ST_MOVE: begin
                    if (last) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign done       = done_q;
    assign fault      = fault_q;
    assign fault_code = code_q;

    assign mem_addr  = cur_addr;
    assign mem_we    = moving && dir_store;
    assign mem_re    = moving && !dir_store;
    assign mem_wdata = store_byte;
    assign rf_ridx   = cur_reg;
    assign rf_we     = moving && !dir_store;
    assign rf_widx   = cur_reg;
    assign rf_wlane  = cur_lane;
    assign rf_wdata  = mem_rdata;

    // R1: busy only drops together with the completion pulse
    p_busy_end_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R2: completion is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: a fault never overlaps busy or completion
    p_fault_alone_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, fault, busy}));

    // R12: a fault comes from an idle block and starts no transfer
    p_fault_idle_r12: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!$past(busy) && !mem_we && !mem_re));

    // R6: a register write only accompanies a memory read
    p_load_pair_r6: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_re && !mem_we));

endmodule

// File: tb/test_rf_burst_mover.sv
module test_rf_burst_mover;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;

    typedef struct {
        int    kind;   // 0 store byte, 1 load byte, 2 done, 3 fault
        int    cyc;
        int    addr;
        int    data;
        int    rg;
        int    ln;
        int    code;
        string tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_store = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [CNT_W-1:0]  cmd_count = '0;
    logic [4:0]        cmd_reg = '0;
    logic [1:0]        cmd_lane = '0;
    logic              cfg_null_trap = 1'b0;
    logic              cfg_standalone = 1'b1;
    logic [ADDR_W-1:0] cfg_imem_base = 16'h8000;
    logic              busy, done, fault;
    logic [1:0]        fault_code;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we, mem_re;
    logic [7:0]        mem_wdata, mem_rdata;
    logic [4:0]        rf_ridx, rf_widx;
    logic [31:0]       rf_rdata;
    logic              rf_we;
    logic [1:0]        rf_wlane;
    logic [7:0]        rf_wdata;

    logic [7:0]  tb_mem  [65536];
    logic [7:0]  ref_mem [65536];
    logic [31:0] tb_rf   [32];
    logic [31:0] ref_rf  [32];

    item_t q[$];
    int    cyc = 0;
    int    nchk = 0;
    int    nfail = 0;
    int    b_lo = 1;
    int    b_hi = 0;
    bit    finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rf_burst_mover i_rf_burst_mover (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_addr(cmd_addr),
        .cmd_count(cmd_count), .cmd_reg(cmd_reg), .cmd_lane(cmd_lane),
        .cfg_null_trap(cfg_null_trap), .cfg_standalone(cfg_standalone),
        .cfg_imem_base(cfg_imem_base),
        .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_ridx(rf_ridx), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_widx(rf_widx), .rf_wlane(rf_wlane), .rf_wdata(rf_wdata)
    );

    // External memory and register file models
    assign mem_rdata = tb_mem[mem_addr];
    assign rf_rdata  = tb_rf[rf_ridx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) tb_mem[mem_addr] <= mem_wdata;
        if (rf_we)  tb_rf[rf_widx][rf_wlane*8 +: 8] <= rf_wdata;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int exp_code(input bit nt, input bit sa, input int base,
                                    input int addr, input int cnt, input int rg, input int ln);
        if (nt && addr < 4)                                return 1;
        if (sa && (addr >= base || addr + cnt > base))     return 2;
        if (rg * 4 + ln + cnt > 128)                       return 3;
        return 0;
    endfunction

    // Monitor: compares every observed access or pulse with the queue head
    always @(negedge clk) begin
        if (!rst) begin
            check(busy == (cyc >= b_lo && cyc <= b_hi), "R1", "busy",
                  int'(busy), int'(cyc >= b_lo && cyc <= b_hi));
            if (mem_we || mem_re || rf_we || done || fault) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1/R12", "unexpected activity", {mem_we, mem_re, done, fault}, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(cyc == it.cyc, it.tag, "timing", cyc, it.cyc);
                    case (it.kind)
                        0: begin
                            check(mem_we && !mem_re, it.tag, "store strobe", {mem_we, mem_re}, 2);
                            check(int'(mem_addr) == it.addr, it.tag, "store addr", mem_addr, it.addr);
                            check(int'(rf_ridx) == it.rg, it.tag, "read reg", rf_ridx, it.rg);
                            check(int'(mem_wdata) == it.data, it.tag, "store byte", mem_wdata, it.data);
                        end
                        1: begin
                            check(mem_re && rf_we && !mem_we, it.tag, "load strobe", {mem_we, mem_re, rf_we}, 3);
                            check(int'(mem_addr) == it.addr, it.tag, "load addr", mem_addr, it.addr);
                            check(int'(rf_widx) == it.rg, it.tag, "write reg", rf_widx, it.rg);
                            check(int'(rf_wlane) == it.ln, it.tag, "write lane", rf_wlane, it.ln);
                            check(int'(rf_wdata) == it.data, it.tag, "load byte", rf_wdata, it.data);
                        end
                        2: check(done && !fault, it.tag, "done", {done, fault}, 2);
                        default: begin
                            check(fault && !done, it.tag, "fault", {done, fault}, 1);
                            check(int'(fault_code) == it.code, it.tag, "fault code", fault_code, it.code);
                        end
                    endcase
                end
            end
        end
    end

    // Driver: predicts all results of a command, then issues it
    task automatic run_cmd(input bit st, input int addr, input int cnt, input int rg,
                           input int ln, input bit poke, input string tag);
        int k, code;
        item_t it;
        k = cyc;
        code = exp_code(cfg_null_trap, cfg_standalone, int'(cfg_imem_base), addr, cnt, rg, ln);
        it.addr = 0; it.data = 0; it.rg = 0; it.ln = 0; it.code = 0; it.tag = tag;
        if (code != 0) begin
            it.kind = 3; it.cyc = k + 1; it.code = code;
            q.push_back(it);
        end else if (cnt == 0) begin
            it.kind = 2; it.cyc = k + 1;
            q.push_back(it);
        end else begin
            for (int i = 0; i < cnt; i++) begin
                it.addr = addr + i;
                it.rg   = rg + (ln + i) / 4;
                it.ln   = (ln + i) % 4;
                it.cyc  = k + 3 + i;
                if (st) begin
                    it.kind = 0;
                    it.data = int'(ref_rf[it.rg][it.ln*8 +: 8]);
                    ref_mem[it.addr] = 8'(it.data);
                end else begin
                    it.kind = 1;
                    it.data = int'(ref_mem[it.addr]);
                    ref_rf[it.rg][it.ln*8 +: 8] = 8'(it.data);
                end
                q.push_back(it);
            end
            it.kind = 2; it.cyc = k + 3 + cnt; it.addr = 0; it.data = 0; it.rg = 0; it.ln = 0;
            q.push_back(it);
            b_lo = k + 1;
            b_hi = k + 2 + cnt;
        end
        cmd_store = st;
        cmd_addr  = ADDR_W'(addr);
        cmd_count = CNT_W'(cnt);
        cmd_reg   = 5'(rg);
        cmd_lane  = 2'(ln);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            // R1: a second command while busy must be ignored
            repeat (3) @(negedge clk);
            cmd_store = ~st;
            cmd_addr  = 16'h0050;
            cmd_count = 8'd5;
            cmd_reg   = 5'd1;
            cmd_lane  = 2'd0;
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        repeat (cnt + 6) @(negedge clk);
        check(q.size() == 0, tag, "queue drained", q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 65536; i++) begin
            tb_mem[i]  = 8'((i * 7 + 3) ^ (i >> 8));
            ref_mem[i] = tb_mem[i];
        end
        for (int i = 0; i < 32; i++) begin
            tb_rf[i]  = 32'h1F2E3D4C * (i + 1) ^ 32'h00A5005A;
            ref_rf[i] = tb_rf[i];
        end
        repeat (4) @(negedge clk);
        // Reset state
        check(!busy && !done && !fault, "R1", "reset pulses", {busy, done, fault}, 0);
        check(!mem_we && !mem_re && !rf_we, "R12", "reset strobes", {mem_we, mem_re, rf_we}, 0);
        rst = 1'b0;
        @(negedge clk);

        run_cmd(1, 16'h0100, 7, 3, 2, 0, "R3/R4/R5 store wrap");
        run_cmd(0, 16'h0200, 9, 10, 1, 0, "R2/R6 load mid-lane");
        run_cmd(1, 16'h0300, 12, 10, 0, 0, "R6 lanes kept readback");
        run_cmd(1, 16'h0400, 10, 5, 3, 1, "R1 ignore while busy");
        run_cmd(0, 16'h1000, 128, 0, 0, 0, "R4/R7 full file");
        run_cmd(1, 16'h1100, 128, 0, 0, 0, "R5 full file readback");
        run_cmd(0, 16'h0500, 3, 31, 2, 0, "R7 overrun by one");
        run_cmd(0, 16'h0500, 3, 31, 1, 0, "R7 exact end");
        run_cmd(1, 16'h0600, 0, 4, 0, 0, "R11 zero count");

        cfg_null_trap = 1'b1;
        run_cmd(0, 2, 4, 6, 0, 0, "R8 null trap on");
        run_cmd(1, 4, 4, 6, 0, 0, "R8 null trap edge");
        cfg_null_trap = 1'b0;
        run_cmd(1, 2, 4, 6, 0, 0, "R8 null trap off");

        run_cmd(1, 16'h7FFE, 3, 8, 0, 0, "R9 crossing");
        run_cmd(1, 16'h7FFE, 2, 8, 0, 0, "R9 end at base");
        run_cmd(1, 16'h8000, 0, 8, 0, 0, "R9 start at base");
        cfg_standalone = 1'b0;
        run_cmd(1, 16'h7FFE, 3, 8, 0, 0, "R9 guard off");
        run_cmd(0, 16'h9000, 4, 8, 1, 0, "R9 guard off high");

        cfg_standalone = 1'b1;
        cfg_imem_base  = 16'h0002;
        cfg_null_trap  = 1'b1;
        run_cmd(0, 1, 200, 0, 0, 0, "R10 R12 all faults");
        cfg_null_trap  = 1'b0;
        run_cmd(0, 1, 200, 0, 0, 0, "R10 imem over overrun");
        cfg_standalone = 1'b0;
        run_cmd(0, 1, 200, 0, 0, 0, "R10 overrun only");
        cfg_imem_base  = 16'h8000;
        cfg_standalone = 1'b1;

        run_cmd(1, 16'h0700, 5, 30, 3, 0, "R2/R4 tail store");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule